// File: doc/BRIEF.md
# Store-Busy Line Controller

This block looks after one shared, active-low busy line that several memory chips wire-AND together. Any chip, or an outside agent, may pull the line low to ask for a nonvolatile store. Each chip also pulls the line low for as long as its own store runs, whatever started that store. The controller sees the resolved line level through a synchronizer. It filters out short low glitches. When a pin request is accepted, it lets ordinary SRAM traffic carry on for a short grace window, and ends that window early on any new bus activity or any write attempt.

The block also decides when the local SRAM may be accessed. Access is closed during a store and during a power-down probe. After a store completes, access stays closed until the shared line is seen high again, so a chip that finishes early waits for its slower neighbours. A low-voltage flag stops pin and software stores. A power-down store first pulls the line and checks that it really falls; if something outside holds the line high, the attempt is dropped.

Top module: `store_busy_ctrl`

## Requirements
- R1: The first cycle after a synchronous reset shows `pull_low` = 0, `store_start` = 0 and `access_en` = 1.
- R2: An external low on `line_in` is taken as a store request only when the synchronized line reads low for more than `MIN_PULSE` consecutive clock cycles. A shorter low is dropped without any store.
- R3: From acceptance of a pin request, `access_en` stays 1 for `GRACE_CYC` cycles and `store_start` follows in the next cycle. A `bus_active` pulse inside the window drops `access_en` in that same cycle, and the store starts in the next cycle.
- R4: A `wr_req` inside the grace window drops `access_en` in that same cycle, so the write is not performed, and `store_start` is asserted in the next cycle.
- R5: Every store begins with a one-cycle `store_start` pulse. `pull_low` is 1 from that cycle until the cycle in which `store_done` is sampled. A software request (`sw_store_req`) starts the store in the next cycle.
- R6: After `store_done`, `pull_low` returns to 0 and `access_en` stays 0 until the synchronized line reads high. With the default two-stage synchronizer, access reopens three cycles after `line_in` rises.
- R7: While `low_vcap` = 1, pin and software requests cause no store and no pull. If `low_vcap` rises during the grace window, the pending pin store is dropped.
- R8: A `pd_store_req` sets `pull_low` from the next cycle. A store starts as soon as the synchronized line reads low. If the line has not read low after `PROBE_CYC` cycles (which must exceed the synchronizer depth plus one), the pull is released and no store starts.
- R9: `access_en` is 0 in every cycle in which `pull_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Resolved wired-AND level of the shared busy line (asynchronous) |
| bus_active | input | 1 | Pulse marking an address or control transition on the SRAM bus |
| wr_req | input | 1 | An SRAM write is being attempted this cycle |
| low_vcap | input | 1 | Storage supply is below the switching threshold |
| sw_store_req | input | 1 | Store request from the software sequence detector |
| pd_store_req | input | 1 | Automatic power-down store attempt |
| store_done | input | 1 | Store engine reports completion |
| pull_low | output | 1 | Enable of the open-drain pull-down on the busy line |
| store_start | output | 1 | One-cycle pulse that launches the store engine |
| access_en | output | 1 | SRAM read and write accesses are allowed |

## Verification
The properties assume that `store_done` is only pulsed while a store is running, and never during a power-down probe or while idle. The bench follows this: it raises `store_done` only after it has seen `store_start`. The checks also assume that `line_in` is the wired-AND of the block's own pull and any outside drivers. The bench builds `line_in` from `pull_low` and its own low or high forcing, and changes it only on falling clock edges. The low-voltage property assumes `low_vcap` changes only while no power-down probe is running. The stimulus keeps to this.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_QUAL  = 3'd1,
        ST_GRACE = 3'd2,
        ST_PROBE = 3'd3,
        ST_STORE = 3'd4,
        ST_HOLD  = 3'd5
    } sbc_state_e;

    typedef struct packed {
        logic sw_req;
        logic pd_req;
        logic wr;
        logic act;
        logic vlow;
        logic done;
    } sbc_evt_t;

    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbc_timer.sv
module sbc_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (cnt != '1)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sbc_fsm.sv
module sbc_fsm
    import sbc_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 4,
    parameter int unsigned GRACE_CYC = 8,
    parameter int unsigned PROBE_CYC = 4,
    parameter int unsigned CW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_low,
    input  sbc_evt_t      evt,
    input  logic [CW-1:0] cnt,
    output logic          clr,
    output logic          pull_low,
    output logic          store_start,
    output logic          access_en
);
    localparam logic [CW-1:0] QUAL_LAST  = CW'(MIN_PULSE - 1);
    localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] PROBE_LAST = CW'(PROBE_CYC - 1);

    sbc_state_e state_q, state_d;
    logic       start_now, start_q;

    always_comb begin
        state_d   = state_q;
        start_now = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (evt.pd_req)                     state_d = ST_PROBE;
                else if (!evt.vlow && evt.sw_req) begin
                    start_now = 1'b1;
                    state_d   = ST_STORE;
                end
                else if (!evt.vlow && line_low)     state_d = ST_QUAL;
            end
            ST_QUAL: begin
                if (evt.vlow || !line_low)          state_d = ST_IDLE;
                else if (cnt == QUAL_LAST)          state_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (evt.vlow)                       state_d = ST_IDLE;
                else if (evt.wr || evt.act || cnt == GRACE_LAST) begin
                    start_now = 1'b1;
                    state_d   = ST_STORE;
                end
            end
            ST_PROBE: begin
                if (line_low) begin
                    start_now = 1'b1;
                    state_d   = ST_STORE;
                end
                else if (cnt == PROBE_LAST)         state_d = ST_IDLE;
            end
            ST_STORE: begin
                if (evt.done)                       state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!line_low)                      state_d = ST_IDLE;
            end
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start_now;
        end
    end

    assign clr         = (state_d != state_q);
    assign store_start = start_q;
    assign pull_low    = (state_q == ST_PROBE) || (state_q == ST_STORE);
    assign access_en   = (state_q == ST_IDLE) || (state_q == ST_QUAL) ||
                         ((state_q == ST_GRACE) && !(evt.wr || evt.act));
endmodule

// File: rtl/store_busy_ctrl.sv
module store_busy_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 4,
    parameter int unsigned GRACE_CYC   = 8,
    parameter int unsigned PROBE_CYC   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic bus_active,
    input  logic wr_req,
    input  logic low_vcap,
    input  logic sw_store_req,
    input  logic pd_store_req,
    input  logic store_done,
    output logic pull_low,
    output logic store_start,
    output logic access_en
);
    localparam int unsigned MAXC = max3(MIN_PULSE, GRACE_CYC, PROBE_CYC);
    localparam int unsigned CW   = cnt_width(MAXC);

    logic          line_q;
    logic          clr;
    logic [CW-1:0] cnt;
    sbc_evt_t      evt;

    assign evt = '{sw_req: sw_store_req, pd_req: pd_store_req, wr: wr_req,
                   act: bus_active, vlow: low_vcap, done: store_done};

    sbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_q)
    );

    sbc_timer #(.W(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .cnt (cnt)
    );

    sbc_fsm #(
        .MIN_PULSE (MIN_PULSE),
        .GRACE_CYC (GRACE_CYC),
        .PROBE_CYC (PROBE_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .line_low    (!line_q),
        .evt         (evt),
        .cnt         (cnt),
        .clr         (clr),
        .pull_low    (pull_low),
        .store_start (store_start),
        .access_en   (access_en)
    );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker (
    input logic clk,
    input logic rst,
    input logic low_vcap,
    input logic store_done,
    input logic pull_low,
    input logic store_start,
    input logic access_en
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pull_low && !store_start && access_en));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        store_start |=> !store_start);

    a_r5_drive_on_start: assert property (@(posedge clk) disable iff (rst)
        store_start |-> pull_low);

    a_r6_hold_after_done: assert property (@(posedge clk) disable iff (rst)
        (store_done && pull_low) |=> (!pull_low && !access_en));

    a_r7_vcap_blocks: assert property (@(posedge clk) disable iff (rst)
        ($past(low_vcap) && !$past(pull_low)) |-> !store_start);

    a_r9_no_access_while_pulled: assert property (@(posedge clk) disable iff (rst)
        pull_low |-> !access_en);
endmodule

bind store_busy_ctrl sbc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .low_vcap    (low_vcap),
    .store_done  (store_done),
    .pull_low    (pull_low),
    .store_start (store_start),
    .access_en   (access_en)
);

// File: tb/tb_store_busy_ctrl.sv
module tb_store_busy_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0, ext_high = 1'b0;
    logic bus_active = 1'b0, wr_req = 1'b0, low_vcap = 1'b0;
    logic sw_store_req = 1'b0, pd_store_req = 1'b0, store_done = 1'b0;
    logic pull_low, store_start, access_en, line_in;
    int   checks = 0, errors = 0, starts = 0;

    always #4 clk = ~clk;

    assign line_in = ext_high ? 1'b1 : !(pull_low | ext_low);

    store_busy_ctrl dut (
        .clk(clk), .rst(rst), .line_in(line_in), .bus_active(bus_active),
        .wr_req(wr_req), .low_vcap(low_vcap), .sw_store_req(sw_store_req),
        .pd_store_req(pd_store_req), .store_done(store_done),
        .pull_low(pull_low), .store_start(store_start), .access_en(access_en)
    );

    always @(negedge clk) if (!rst && store_start) starts++;

    localparam int NV = 5;
    localparam int VEC_LEN [NV] = '{2, 4, 5, 9, 3};
    localparam int VEC_EXP [NV] = '{0, 0, 1, 1, 0};

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_store();
        store_done = 1'b1;
        ext_low    = 1'b0;
        cyc(1);
        store_done = 1'b0;
        cyc(4);
        check("R6 access reopens", access_en, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        check("R1 pull_low", pull_low, 0);
        check("R1 store_start", store_start, 0);
        check("R1 access_en", access_en, 1);

        // R2 pulse-width table
        for (int v = 0; v < NV; v++) begin
            s0 = starts;
            ext_low = 1'b1;
            cyc(VEC_LEN[v]);
            ext_low = 1'b0;
            cyc(20);
            check("R2 pulse qualification", starts - s0, VEC_EXP[v]);
            if (VEC_EXP[v] != 0) finish_store();
            else cyc(2);
        end

        // R3 full grace window, R5 drive, R6 hold while neighbour holds line
        s0 = starts;
        ext_low = 1'b1;
        cyc(14);
        check("R3 access during grace", access_en, 1);
        check("R3 no early start", store_start, 0);
        cyc(1);
        check("R3 start after grace", store_start, 1);
        check("R5 pull during store", pull_low, 1);
        check("R9 access closed", access_en, 0);
        cyc(1);
        check("R5 single pulse", store_start, 0);
        store_done = 1'b1;
        cyc(1);
        store_done = 1'b0;
        check("R5 release at done", pull_low, 0);
        check("R6 closed after done", access_en, 0);
        cyc(5);
        check("R6 closed while line low", access_en, 0);
        ext_low = 1'b0;
        cyc(2);
        check("R6 closed before sync", access_en, 0);
        cyc(1);
        check("R6 reopen after sync", access_en, 1);
        cyc(3);

        // R4 write inside grace window
        ext_low = 1'b1;
        cyc(9);
        wr_req = 1'b1;
        #1;
        check("R4 write blocked", access_en, 0);
        cyc(1);
        wr_req = 1'b0;
        check("R4 store after write", store_start, 1);
        finish_store();

        // R3 bus activity inside grace window
        ext_low = 1'b1;
        cyc(11);
        check("R3 access before activity", access_en, 1);
        bus_active = 1'b1;
        #1;
        check("R3 activity closes access", access_en, 0);
        cyc(1);
        bus_active = 1'b0;
        check("R3 store after activity", store_start, 1);
        finish_store();

        // R5 software store
        sw_store_req = 1'b1;
        cyc(1);
        sw_store_req = 1'b0;
        check("R5 sw start", store_start, 1);
        check("R5 sw pull", pull_low, 1);
        finish_store();

        // R7 low voltage
        s0 = starts;
        low_vcap = 1'b1;
        ext_low = 1'b1;
        cyc(25);
        check("R7 pin blocked pull", pull_low, 0);
        check("R7 pin blocked access", access_en, 1);
        ext_low = 1'b0;
        sw_store_req = 1'b1;
        cyc(1);
        sw_store_req = 1'b0;
        cyc(3);
        check("R7 no store under low voltage", starts - s0, 0);
        low_vcap = 1'b0;
        cyc(4);
        ext_low = 1'b1;
        cyc(9);
        low_vcap = 1'b1;
        cyc(10);
        check("R7 grace dropped", starts - s0, 0);
        check("R7 grace dropped pull", pull_low, 0);
        ext_low = 1'b0;
        cyc(4);
        low_vcap = 1'b0;
        cyc(2);

        // R8 power-down probe with line held high
        s0 = starts;
        ext_high = 1'b1;
        pd_store_req = 1'b1;
        cyc(1);
        pd_store_req = 1'b0;
        check("R8 probe pulls", pull_low, 1);
        check("R9 probe closes access", access_en, 0);
        cyc(3);
        check("R8 still probing", pull_low, 1);
        cyc(1);
        check("R8 probe abandoned", pull_low, 0);
        check("R8 no store on abort", starts - s0, 0);
        ext_high = 1'b0;
        cyc(3);

        // R8 power-down probe where the line falls
        pd_store_req = 1'b1;
        cyc(1);
        pd_store_req = 1'b0;
        cyc(2);
        check("R8 no start yet", store_start, 0);
        cyc(1);
        check("R8 store on line low", store_start, 1);
        finish_store();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule